// File: doc/BRIEF.md
# Mode-register-7 command router

This block sits at the command input of a registering clock driver on a buffered memory module. In every cycle it looks at the decoded command pins. It picks out one kind of command: a mode-register write to register number 7, aimed at chip select 0. That command is not sent on to the DRAM. It is an escape command for the module itself, and address bit 12 selects its target. With the bit clear, the command programs one of the driver's own 27 control words. With the bit set, the low twelve address bits go out on a port that feeds the data buffers.

All other commands are copied to the output command port through one register stage, with their fields unchanged. A side read port makes every control word visible. One 4-bit word holds power-saving settings. Its bit 0 enables input-bus termination. Its bit 1 enables an idle power-down indication, which is raised in the cycle after one in which every chip select is high.

Top module: `mr7_cmd_router`

## Requirements
- R1: After reset, `cmdReady` is 1, `fwdValid`, `bufValid`, `ibtEnable`, `idlePdEnable` and `chanPowerDown` are 0, and every control word reads 0.
- R2: An accepted command that is not an escape command appears on the `fwd*` outputs one clock later, with all fields equal to the input fields, and `fwdValid` is high for that one cycle only.
- R3: A command is an escape command only when all of the following hold: `actN`=1, `rasN`=`casN`=`weN`=0, `csN[0]`=0 and `bg[1]`=0. In addition, the mode-register number `{bg[0],ba[1],ba[0]}` must equal 7. Any other command is forwarded as in R2.
- R4: An escape command with `addr[12]`=0 writes a control word. It is not forwarded, and `bufValid` stays 0.
- R5: An escape command with `addr[12]`=1 raises `bufValid` for one cycle, one clock later, with `bufWord` = `addr[11:0]`. It is not forwarded and leaves the control words unchanged.
- R6: The control-word index depends on `addr[11:8]`. When `addr[11:8]`=0, the word is a 4-bit word with index `addr[7:4]` (indices 0..13 are defined), and its payload is `addr[3:0]`, stored with zeros in the upper four bits. When `addr[11:8]`=k with k from 1 to 13, the word is an 8-bit word with index 13+k, and its payload is `addr[7:0]`.
- R7: A control-word write to an undefined index (`addr[11:8]`=0 with `addr[7:4]`>=14, or `addr[11:8]`>=14) changes no word, forwards nothing, raises `bufValid` to no cycle and keeps `cmdReady` high.
- R8: The written value of a control word can be read from the first cycle after the write is accepted. `cmdReady` is 0 for exactly that one cycle, and any command presented in that cycle is dropped.
- R9: Word 9 is the power-saving word. Its bit 0 drives `ibtEnable` and its bit 1 drives `idlePdEnable`.
- R10: `chanPowerDown` is registered. It is 1 in the cycle after a cycle in which `idlePdEnable` was 1 and every bit of `csN` was 1. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present this cycle |
| csN | input | CS_W | Chip selects, active low |
| actN | input | 1 | Activate pin, active low |
| rasN | input | 1 | Row strobe / command pin |
| casN | input | 1 | Column strobe / command pin |
| weN | input | 1 | Write-enable / command pin |
| bg | input | 2 | Bank group |
| ba | input | 2 | Bank address |
| addr | input | ADDR_W | Address bus |
| cmdReady | output | 1 | Low in the single cycle after a control-word write |
| fwdValid | output | 1 | Forwarded command valid |
| fwdCsN | output | CS_W | Forwarded chip selects |
| fwdActN | output | 1 | Forwarded activate pin |
| fwdRasN | output | 1 | Forwarded row strobe |
| fwdCasN | output | 1 | Forwarded column strobe |
| fwdWeN | output | 1 | Forwarded write enable |
| fwdBg | output | 2 | Forwarded bank group |
| fwdBa | output | 2 | Forwarded bank address |
| fwdAddr | output | ADDR_W | Forwarded address |
| bufValid | output | 1 | Buffer control word valid |
| bufWord | output | 12 | Buffer control word (identifier and payload) |
| cwRdIdx | input | 5 | Control-word read index |
| cwRdData | output | 8 | Control word at `cwRdIdx` (0 if undefined) |
| ibtEnable | output | 1 | Input-bus termination enable |
| idlePdEnable | output | 1 | Idle power-down enable |
| chanPowerDown | output | 1 | Channel idle power-down indication |

## Verification
A wrong decode of the pin pattern or of bit 12 shows up one clock after the command. The command then appears on the wrong port: forwarded instead of absorbed, or sent to the buffers instead of written. A control word stored in the wrong place or with the wrong width is visible on the side read port in the first cycle after the write. For word 9, the error also reaches `ibtEnable`, `idlePdEnable` and, one cycle later, `chanPowerDown`. If the bubble logic is wrong, `cmdReady` fails to drop, or a command given in the bubble cycle still appears one clock later.

// File: rtl/mr7r_pkg.sv
package mr7r_pkg;
  localparam int CW4_COUNT = 14;
  localparam int CW8_COUNT = 13;
  localparam int CW_COUNT  = CW4_COUNT + CW8_COUNT;
  localparam int CW_IDX_W  = $clog2(CW_COUNT);
  localparam int CW_DATA_W = 8;
  localparam int BUF_W     = 12;
  localparam int ROUTE_BIT = 12;
  localparam int PWR_SLOT  = 9;

  typedef logic [CW_IDX_W-1:0] cwIdx_t;

  typedef enum logic [1:0] {
    KIND_DROP,
    KIND_PLAIN,
    KIND_RCW,
    KIND_BCW
  } cmdKind_e;

  typedef struct packed {
    logic                 fwdLoad;
    logic                 bufLoad;
    logic                 cwWrite;
    cwIdx_t               cwSlot;
    logic [CW_DATA_W-1:0] cwData;
  } strobe_t;
endpackage

// File: rtl/mr7r_ctrl.sv
module mr7r_ctrl
  import mr7r_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cs0N,
  input  logic              actN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [1:0]        bg,
  input  logic [1:0]        ba,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           stb,
  output logic              cmdReady
);
  logic     busy;
  logic     accept;
  logic     isMrs;
  logic     isEscape;
  logic [3:0] cls;
  logic [3:0] sub;
  logic     slotValid;
  cwIdx_t   slot;
  cmdKind_e kind;

  assign accept   = cmdValid && !busy;
  assign cmdReady = !busy;
  assign isMrs    = actN && !rasN && !casN && !weN;
  assign isEscape = isMrs && !cs0N && !bg[1] && ({bg[0], ba} == 3'd7);
  assign cls      = addr[11:8];
  assign sub      = addr[7:4];

  // Control-word index decode
  always_comb begin
    if (cls == 4'd0) begin
      slotValid = int'(sub) < CW4_COUNT;
      slot      = CW_IDX_W'(sub);
    end else begin
      slotValid = (int'(cls) - 1) < CW8_COUNT;
      slot      = CW_IDX_W'(CW4_COUNT + int'(cls) - 1);
    end
  end

  always_comb begin
    if (!accept)              kind = KIND_DROP;
    else if (!isEscape)       kind = KIND_PLAIN;
    else if (addr[ROUTE_BIT]) kind = KIND_BCW;
    else                      kind = KIND_RCW;
  end

  always_comb begin
    stb.fwdLoad = (kind == KIND_PLAIN);
    stb.bufLoad = (kind == KIND_BCW);
    stb.cwWrite = (kind == KIND_RCW) && slotValid;
    stb.cwSlot  = slot;
    stb.cwData  = (cls == 4'd0) ? {4'b0000, addr[3:0]} : addr[7:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) busy <= 1'b0;
    else       busy <= stb.cwWrite;
  end

  // R8
  write_bubble_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.cwWrite |=> !cmdReady);

  // R8
  bubble_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmdReady |=> cmdReady);
endmodule

// File: rtl/mr7r_dpath.sv
module mr7r_dpath
  import mr7r_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int CS_W   = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [CS_W-1:0]      csN,
  input  logic                 actN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic [1:0]           bg,
  input  logic [1:0]           ba,
  input  logic [ADDR_W-1:0]    addr,
  input  cwIdx_t               cwRdIdx,
  output logic                 fwdValid,
  output logic [CS_W-1:0]      fwdCsN,
  output logic                 fwdActN,
  output logic                 fwdRasN,
  output logic                 fwdCasN,
  output logic                 fwdWeN,
  output logic [1:0]           fwdBg,
  output logic [1:0]           fwdBa,
  output logic [ADDR_W-1:0]    fwdAddr,
  output logic                 bufValid,
  output logic [BUF_W-1:0]     bufWord,
  output logic [CW_DATA_W-1:0] cwRdData,
  output logic                 ibtEnable,
  output logic                 idlePdEnable,
  output logic                 chanPowerDown
);
  logic [CW_DATA_W-1:0] cwFile [CW_COUNT];

  for (genvar g = 0; g < CW_COUNT; g++) begin : g_cw
    always_ff @(posedge clk) begin
      if (!rstN)
        cwFile[g] <= '0;
      else if (stb.cwWrite && (int'(stb.cwSlot) == g))
        cwFile[g] <= stb.cwData;
    end
  end

  assign cwRdData     = (int'(cwRdIdx) < CW_COUNT) ? cwFile[cwRdIdx] : '0;
  assign ibtEnable    = cwFile[PWR_SLOT][0];
  assign idlePdEnable = cwFile[PWR_SLOT][1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fwdValid <= 1'b0;
      fwdCsN   <= '1;
      fwdActN  <= 1'b1;
      fwdRasN  <= 1'b1;
      fwdCasN  <= 1'b1;
      fwdWeN   <= 1'b1;
      fwdBg    <= '0;
      fwdBa    <= '0;
      fwdAddr  <= '0;
    end else begin
      fwdValid <= stb.fwdLoad;
      if (stb.fwdLoad) begin
        fwdCsN  <= csN;
        fwdActN <= actN;
        fwdRasN <= rasN;
        fwdCasN <= casN;
        fwdWeN  <= weN;
        fwdBg   <= bg;
        fwdBa   <= ba;
        fwdAddr <= addr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufValid <= 1'b0;
      bufWord  <= '0;
    end else begin
      bufValid <= stb.bufLoad;
      if (stb.bufLoad) bufWord <= addr[BUF_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) chanPowerDown <= 1'b0;
    else       chanPowerDown <= idlePdEnable && (&csN);
  end

  // R2
  fwd_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.fwdLoad |=> fwdValid && (fwdAddr == $past(addr)) && (fwdCsN == $past(csN)));

  // R5
  buf_payload_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.bufLoad |=> bufValid && (bufWord == $past(addr[BUF_W-1:0])));

  // R7
  cw_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.cwWrite |=> (cwRdIdx != $past(cwRdIdx)) || (cwRdData == $past(cwRdData)));
endmodule

// File: rtl/mr7_cmd_router.sv
module mr7_cmd_router
  import mr7r_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int CS_W   = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic [CS_W-1:0]      csN,
  input  logic                 actN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic [1:0]           bg,
  input  logic [1:0]           ba,
  input  logic [ADDR_W-1:0]    addr,
  output logic                 cmdReady,
  output logic                 fwdValid,
  output logic [CS_W-1:0]      fwdCsN,
  output logic                 fwdActN,
  output logic                 fwdRasN,
  output logic                 fwdCasN,
  output logic                 fwdWeN,
  output logic [1:0]           fwdBg,
  output logic [1:0]           fwdBa,
  output logic [ADDR_W-1:0]    fwdAddr,
  output logic                 bufValid,
  output logic [BUF_W-1:0]     bufWord,
  input  logic [CW_IDX_W-1:0]  cwRdIdx,
  output logic [CW_DATA_W-1:0] cwRdData,
  output logic                 ibtEnable,
  output logic                 idlePdEnable,
  output logic                 chanPowerDown
);
  strobe_t stb;

  mr7r_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cs0N(csN[0]),
    .actN(actN), .rasN(rasN), .casN(casN), .weN(weN),
    .bg(bg), .ba(ba), .addr(addr), .stb(stb), .cmdReady(cmdReady)
  );

  mr7r_dpath #(.ADDR_W(ADDR_W), .CS_W(CS_W)) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .csN(csN), .actN(actN),
    .rasN(rasN), .casN(casN), .weN(weN), .bg(bg), .ba(ba), .addr(addr),
    .cwRdIdx(cwRdIdx), .fwdValid(fwdValid), .fwdCsN(fwdCsN),
    .fwdActN(fwdActN), .fwdRasN(fwdRasN), .fwdCasN(fwdCasN),
    .fwdWeN(fwdWeN), .fwdBg(fwdBg), .fwdBa(fwdBa), .fwdAddr(fwdAddr),
    .bufValid(bufValid), .bufWord(bufWord), .cwRdData(cwRdData),
    .ibtEnable(ibtEnable), .idlePdEnable(idlePdEnable),
    .chanPowerDown(chanPowerDown)
  );

  // R4
  route_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(fwdValid && bufValid));

  // R8
  bubble_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmdReady |=> !fwdValid && !bufValid);
endmodule

// File: tb/mr7_cmd_router_tb_top.sv
module mr7_cmd_router_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        cmdValid;
  logic [1:0]  csN;
  logic        actN, rasN, casN, weN;
  logic [1:0]  bg, ba;
  logic [12:0] addr;
  logic        cmdReady, fwdValid;
  logic [1:0]  fwdCsN;
  logic        fwdActN, fwdRasN, fwdCasN, fwdWeN;
  logic [1:0]  fwdBg, fwdBa;
  logic [12:0] fwdAddr;
  logic        bufValid;
  logic [11:0] bufWord;
  logic [4:0]  cwRdIdx;
  logic [7:0]  cwRdData;
  logic        ibtEnable, idlePdEnable, chanPowerDown;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;
  int expCw [27];

  always #5 clk = ~clk;

  mr7_cmd_router #(.ADDR_W(13), .CS_W(2)) dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .csN(csN), .actN(actN),
    .rasN(rasN), .casN(casN), .weN(weN), .bg(bg), .ba(ba), .addr(addr),
    .cmdReady(cmdReady), .fwdValid(fwdValid), .fwdCsN(fwdCsN),
    .fwdActN(fwdActN), .fwdRasN(fwdRasN), .fwdCasN(fwdCasN),
    .fwdWeN(fwdWeN), .fwdBg(fwdBg), .fwdBa(fwdBa), .fwdAddr(fwdAddr),
    .bufValid(bufValid), .bufWord(bufWord), .cwRdIdx(cwRdIdx),
    .cwRdData(cwRdData), .ibtEnable(ibtEnable), .idlePdEnable(idlePdEnable),
    .chanPowerDown(chanPowerDown)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    cmdValid = 1'b0; csN = 2'b11; actN = 1'b1; rasN = 1'b1; casN = 1'b1;
    weN = 1'b1; bg = 2'b00; ba = 2'b00; addr = '0;
  endtask

  // Drive at a falling edge, let one rising edge pass, sample at the next falling edge.
  task automatic issue(input logic [1:0] c, input logic a, input logic r,
                       input logic s, input logic w, input logic [1:0] g,
                       input logic [1:0] b, input logic [12:0] ad);
    cmdValid = 1'b1; csN = c; actN = a; rasN = r; casN = s; weN = w;
    bg = g; ba = b; addr = ad;
    @(posedge clk); @(negedge clk);
    idle();
  endtask

  task automatic mrw(input logic [2:0] mr, input logic [12:0] ad);
    issue(2'b10, 1'b1, 1'b0, 1'b0, 1'b0, {1'b0, mr[2]}, mr[1:0], ad);
  endtask

  task automatic gap();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic checkFile(input string req);
    for (int i = 0; i < 27; i++) begin
      cwRdIdx = 5'(i); #1;
      chk(cwRdData == 8'(expCw[i]), req, $sformatf("word %0d", i), cwRdData, expCw[i]);
    end
  endtask

  task automatic checkFwd(input string req, input logic [1:0] c, input logic a,
                          input logic r, input logic s, input logic w,
                          input logic [1:0] g, input logic [1:0] b,
                          input logic [12:0] ad);
    chk(fwdValid == 1'b1, req, "fwdValid", fwdValid, 1);
    chk({fwdCsN, fwdActN, fwdRasN, fwdCasN, fwdWeN, fwdBg, fwdBa} ==
        {c, a, r, s, w, g, b}, req, "fwd pins",
        {fwdCsN, fwdActN, fwdRasN, fwdCasN, fwdWeN, fwdBg, fwdBa},
        {c, a, r, s, w, g, b});
    chk(fwdAddr == ad, req, "fwdAddr", fwdAddr, ad);
    chk(bufValid == 1'b0, req, "bufValid", bufValid, 0);
  endtask

  // Write a defined control word; check at the first cycle after acceptance.
  task automatic wrCw(input logic [12:0] ad, input int slot, input int val);
    mrw(3'd7, ad);
    expCw[slot] = val;
    chk(fwdValid == 1'b0, "R4", "fwdValid on cw write", fwdValid, 0);
    chk(bufValid == 1'b0, "R4", "bufValid on cw write", bufValid, 0);
    chk(cmdReady == 1'b0, "R8", "cmdReady in bubble", cmdReady, 0);
    cwRdIdx = 5'(slot); #1;
    chk(cwRdData == 8'(val), "R6", $sformatf("word %0d value", slot), cwRdData, val);
    gap();
    chk(cmdReady == 1'b1, "R8", "cmdReady after bubble", cmdReady, 1);
  endtask

  task automatic testReset();
    chk(cmdReady == 1'b1, "R1", "cmdReady", cmdReady, 1);
    chk(fwdValid == 1'b0, "R1", "fwdValid", fwdValid, 0);
    chk(bufValid == 1'b0, "R1", "bufValid", bufValid, 0);
    chk(ibtEnable == 1'b0, "R1", "ibtEnable", ibtEnable, 0);
    chk(idlePdEnable == 1'b0, "R1", "idlePdEnable", idlePdEnable, 0);
    chk(chanPowerDown == 1'b0, "R1", "chanPowerDown", chanPowerDown, 0);
    checkFile("R1");
  endtask

  task automatic testForward();
    issue(2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 2'b01, 2'b10, 13'h0123);
    checkFwd("R2", 2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 2'b01, 2'b10, 13'h0123);
    mrw(3'd3, 13'h0456);
    checkFwd("R2", 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 2'b11, 13'h0456);
    gap();
    chk(fwdValid == 1'b0, "R2", "fwdValid one cycle", fwdValid, 0);
    // R3: near misses of the escape pattern are plain commands
    issue(2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 2'b01, 2'b11, 13'h0012);
    checkFwd("R3", 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 2'b01, 2'b11, 13'h0012);
    issue(2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 2'b11, 2'b11, 13'h0012);
    checkFwd("R3", 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 2'b11, 2'b11, 13'h0012);
    issue(2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01, 2'b11, 13'h0012);
    checkFwd("R3", 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01, 2'b11, 13'h0012);
    mrw(3'd6, 13'h0012);
    checkFwd("R3", 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 2'b01, 2'b10, 13'h0012);
    checkFile("R3");
  endtask

  task automatic testCwWrite();
    wrCw(13'h003A, 3, 8'h0A);
    wrCw(13'h05C3, 18, 8'hC3);
    wrCw(13'h0D5A, 26, 8'h5A);
    wrCw(13'h01FF, 14, 8'hFF);
    wrCw(13'h00D7, 13, 8'h07);
    wrCw(13'h0037, 3, 8'h07);
    checkFile("R6");
  endtask

  task automatic testUndefined();
    mrw(3'd7, 13'h00E9);
    chk(cmdReady == 1'b1, "R7", "cmdReady sub 14", cmdReady, 1);
    chk(fwdValid == 1'b0 && bufValid == 1'b0, "R7", "outputs sub 14",
        {fwdValid, bufValid}, 0);
    mrw(3'd7, 13'h0E44);
    chk(cmdReady == 1'b1, "R7", "cmdReady class 14", cmdReady, 1);
    mrw(3'd7, 13'h0F11);
    chk(cmdReady == 1'b1, "R7", "cmdReady class 15", cmdReady, 1);
    checkFile("R7");
  endtask

  task automatic testBufWord();
    mrw(3'd7, 13'h1ABC);
    chk(bufValid == 1'b1, "R5", "bufValid", bufValid, 1);
    chk(bufWord == 12'hABC, "R5", "bufWord", bufWord, 12'hABC);
    chk(fwdValid == 1'b0, "R5", "fwdValid", fwdValid, 0);
    chk(cmdReady == 1'b1, "R5", "cmdReady", cmdReady, 1);
    gap();
    chk(bufValid == 1'b0, "R5", "bufValid one cycle", bufValid, 0);
    checkFile("R5");
  endtask

  task automatic testBubble();
    wrCw(13'h0021, 2, 8'h01);
    mrw(3'd7, 13'h0021);
    issue(2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 2'b00, 2'b00, 13'h0077);
    chk(fwdValid == 1'b0, "R8", "plain cmd dropped in bubble", fwdValid, 0);
    mrw(3'd7, 13'h0041);
    expCw[4] = 8'h01;
    mrw(3'd7, 13'h0042);
    chk(cmdReady == 1'b1, "R8", "dropped write no bubble", cmdReady, 1);
    mrw(3'd7, 13'h0021);
    mrw(3'd7, 13'h1555);
    chk(bufValid == 1'b0, "R8", "buffer cmd dropped in bubble", bufValid, 0);
    checkFile("R8");
  endtask

  task automatic testPower();
    wrCw(13'h0093, 9, 8'h03);
    chk(ibtEnable == 1'b1, "R9", "ibtEnable", ibtEnable, 1);
    chk(idlePdEnable == 1'b1, "R9", "idlePdEnable", idlePdEnable, 1);
    chk(chanPowerDown == 1'b1, "R10", "chanPowerDown idle", chanPowerDown, 1);
    issue(2'b01, 1'b1, 1'b1, 1'b0, 1'b1, 2'b00, 2'b00, 13'h0005);
    chk(chanPowerDown == 1'b0, "R10", "chanPowerDown cs active", chanPowerDown, 0);
    gap();
    chk(chanPowerDown == 1'b1, "R10", "chanPowerDown back idle", chanPowerDown, 1);
    wrCw(13'h0091, 9, 8'h01);
    chk(ibtEnable == 1'b1, "R9", "ibtEnable kept", ibtEnable, 1);
    chk(idlePdEnable == 1'b0, "R9", "idlePdEnable cleared", idlePdEnable, 0);
    chk(chanPowerDown == 1'b0, "R10", "chanPowerDown disabled", chanPowerDown, 0);
  endtask

  initial begin
    for (int i = 0; i < 27; i++) expCw[i] = 0;
    idle();
    cwRdIdx = '0;
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testForward();
    testCwWrite();
    testUndefined();
    testBufWord();
    testBubble();
    testPower();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule